// File: doc/BRIEF.md
# Calendar Time and Date Counter

The block holds the current time of day and the calendar date in two packed 32-bit words. Every pulse on the one-second tick input moves them forward. When the time passes 23:59:59 it returns to midnight and the date moves to the next day. The day count follows the length of each month. February's length comes from a leap flag stored in the date word. Across a year boundary the hardware works out the leap flag again from the new year. The year is held as an offset from 1970 in six bits, so the span runs from 1970-01-01 through 2033-12-31.

Software replaces either word with a single-cycle write strobe and a data word. The value is first held in a staging register that belongs to that word. It is applied only on a later pulse of the slow-domain enable. Until then a busy bit in the control word stays set, so software polls that bit before it touches the same word again. The time word and the date word each have their own staging path and their own busy bit. Because the counters keep running while software reads them, a reader takes both words twice and uses them only when the two passes agree.

Top module: `cal_counter`

## Requirements
- R1: After reset, time_o reads 0x00000000 (00:00:00) and date_o reads 0x00000101 (day 1, month 1, offset 0, leap flag 0). ctrl_o reads 0.
- R2: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0. A cycle with sec_tick_i high adds one second. In a cycle with no tick and no commit, time_o holds its value.
- R3: Seconds run 0 to 59 and minutes run 0 to 59, each carrying into the next field. Hours run 0 to 23. A tick at 23:59:59 gives 00:00:00 and advances the date by one day.
- R4: The date word holds the day in bits 4:0, the month (1 to 12) in bits 11:8, the year offset from 1970 in bits 21:16 and the leap flag in bit 22. The day is never 0. After the last day of a month (31 for months 1, 3, 5, 7, 8, 10 and 12; 30 for months 4, 6, 9 and 11) the date goes to day 1 of the next month.
- R5: In month 2, the last day is 29 when the leap flag is 1 and 28 when it is 0.
- R6: After day 31 of month 12 the date goes to day 1 of month 1 and the offset rises by one. The leap flag then becomes 1 exactly when (offset + 1970) mod 4 equals 0.
- R7: A time_wr_i strobe while ctrl_o bit 8 is clear sets bit 8 on the next edge and stages the masked data. Counting the write cycle as none, the value is loaded into time_o on the edge of the second slow_en_i pulse after the write, and bit 8 clears on that same edge. Until that edge, time_o keeps counting from its old value.
- R8: A date_wr_i strobe works the same way through ctrl_o bit 7 and date_o. The leap flag is taken from the written data. The time path and the date path do not affect each other's busy bit.
- R9: A write strobe to a word whose busy bit is set has no effect. The value staged earlier is the one that is loaded.
- R10: When a commit and a tick fall in the same cycle, the committed value wins. A time commit that replaces 23:59:59 does not advance the date.
- R11: After day 31 of month 12 at offset 63, the date goes to offset 0, month 1, day 1, with the leap flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| slow_en_i | input | 1 | One-cycle pulse, once per slow-domain cycle |
| time_wr_i | input | 1 | Write strobe for the time word |
| date_wr_i | input | 1 | Write strobe for the date word |
| wdata_i | input | 32 | Write data |
| time_o | output | 32 | Packed hours, minutes and seconds |
| date_o | output | 32 | Packed leap flag, year offset, month and day |
| ctrl_o | output | 32 | Bit 8: time commit pending. Bit 7: date commit pending |

## Verification
The bench aims at the edges of each month: 30-day and 31-day months, and February with and without the leap flag. A design with a wrong month table would skip a real day or produce day 31 of April. It also drives the December roll into a new year, including the wrap from offset 63 to offset 0. Here a design with a wrong leap formula would set the flag in the wrong year. Other targets are a second write arriving while a word is busy, which a faulty design would let overwrite the staged value, and a commit landing on the same cycle as a tick at 23:59:59, where a faulty design would add a day on top of the new value. Random writes, ticks and slow pulses are compared against a bench model on every cycle. This catches an early or late commit edge and any cross-talk between the two busy bits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;
  localparam int WORD_W = 32;
  localparam int TIME_BUSY_BIT = 8;
  localparam int DATE_BUSY_BIT = 7;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } hms_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mo;
    logic [DAY_W-1:0] dy;
  } ymd_t;

  localparam int HMS_BITS = $bits(hms_t);
  localparam int YMD_BITS = $bits(ymd_t);

  function automatic hms_t hms_from_word(logic [WORD_W-1:0] w);
    hms_t t;
    t.sc = w[5:0];
    t.mn = w[13:8];
    t.hr = w[20:16];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] hms_to_word(hms_t t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[5:0]   = t.sc;
    w[13:8]  = t.mn;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic ymd_t ymd_from_word(logic [WORD_W-1:0] w);
    ymd_t d;
    d.dy   = w[4:0];
    d.mo   = w[11:8];
    d.yr   = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_to_word(ymd_t d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[4:0]   = d.dy;
    w[11:8]  = d.mo;
    w[21:16] = d.yr;
    w[22]    = d.leap;
    return w;
  endfunction

  function automatic logic [DAY_W-1:0] month_days(logic [MON_W-1:0] mo, logic leap);
    case (mo)
      4'd2:                    return leap ? DAY_W'(29) : DAY_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11: return DAY_W'(30);
      default:                 return DAY_W'(31);
    endcase
  endfunction

  // 1970 mod 4 = 2, so (off + 1970) mod 4 == 0 iff off mod 4 == 2
  function automatic logic leap_of(logic [YR_W-1:0] yr);
    return yr[1:0] == 2'd2;
  endfunction
endpackage

// File: rtl/cal_commit.sv
module cal_commit #(
  parameter int W = 17,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         slow_en_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] stage_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W-1:0]  stage_q;

  assign commit_o = busy_q & slow_en_i & (cnt_q == CW'(N - 1));
  assign busy_o   = busy_q;
  assign stage_o  = stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (!busy_q) begin
      if (wr_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        stage_q <= wdata_i;
      end
    end else if (slow_en_i) begin
      if (commit_o) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_hms.sv
module cal_hms
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  hms_t load_val_i,
  output hms_t hms_o,
  output logic wrap_o
);
  hms_t hms_q, hms_inc;
  logic sc_top, mn_top, hr_top;

  assign sc_top = hms_q.sc >= SEC_W'(59);
  assign mn_top = hms_q.mn >= MIN_W'(59);
  assign hr_top = hms_q.hr >= HR_W'(23);

  always_comb begin
    hms_inc = hms_q;
    if (!sc_top) hms_inc.sc = hms_q.sc + 1'b1;
    else begin
      hms_inc.sc = '0;
      if (!mn_top) hms_inc.mn = hms_q.mn + 1'b1;
      else begin
        hms_inc.mn = '0;
        hms_inc.hr = hr_top ? '0 : hms_q.hr + 1'b1;
      end
    end
  end

  assign wrap_o = tick_i & ~load_i & sc_top & mn_top & hr_top;
  assign hms_o  = hms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hms_q <= '0;
    else if (load_i) hms_q <= load_val_i;
    else if (tick_i) hms_q <= hms_inc;
  end
endmodule

// File: rtl/cal_ymd.sv
module cal_ymd
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic load_i,
  input  ymd_t load_val_i,
  output ymd_t ymd_o
);
  ymd_t ymd_q, ymd_inc;
  logic last_day, last_mon;

  assign last_day = ymd_q.dy >= month_days(ymd_q.mo, ymd_q.leap);
  assign last_mon = ymd_q.mo >= MON_W'(12);

  always_comb begin
    ymd_inc = ymd_q;
    if (!last_day) ymd_inc.dy = ymd_q.dy + 1'b1;
    else begin
      ymd_inc.dy = DAY_W'(1);
      if (!last_mon) ymd_inc.mo = ymd_q.mo + 1'b1;
      else begin
        ymd_inc.mo   = MON_W'(1);
        ymd_inc.yr   = ymd_q.yr + 1'b1;
        ymd_inc.leap = leap_of(ymd_q.yr + 1'b1);
      end
    end
  end

  assign ymd_o = ymd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ymd_q <= '{leap: 1'b0, yr: '0, mo: MON_W'(1), dy: DAY_W'(1)};
    else if (load_i) ymd_q <= load_val_i;
    else if (adv_i)  ymd_q <= ymd_inc;
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int COMMIT_SLOW = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sec_tick_i,
  input  logic        slow_en_i,
  input  logic        time_wr_i,
  input  logic        date_wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] time_o,
  output logic [31:0] date_o,
  output logic [31:0] ctrl_o
);
  logic t_busy, t_commit, d_busy, d_commit, day_wrap;
  logic [HMS_BITS-1:0] t_stage;
  logic [YMD_BITS-1:0] d_stage;
  hms_t hms;
  ymd_t ymd;

  cal_commit #(.W(HMS_BITS), .N(COMMIT_SLOW)) u_time_commit (
    .clk_i, .rst_ni, .wr_i(time_wr_i), .wdata_i(hms_from_word(wdata_i)),
    .slow_en_i, .busy_o(t_busy), .commit_o(t_commit), .stage_o(t_stage)
  );

  cal_commit #(.W(YMD_BITS), .N(COMMIT_SLOW)) u_date_commit (
    .clk_i, .rst_ni, .wr_i(date_wr_i), .wdata_i(ymd_from_word(wdata_i)),
    .slow_en_i, .busy_o(d_busy), .commit_o(d_commit), .stage_o(d_stage)
  );

  cal_hms u_hms (
    .clk_i, .rst_ni, .tick_i(sec_tick_i), .load_i(t_commit),
    .load_val_i(hms_t'(t_stage)), .hms_o(hms), .wrap_o(day_wrap)
  );

  cal_ymd u_ymd (
    .clk_i, .rst_ni, .adv_i(day_wrap), .load_i(d_commit),
    .load_val_i(ymd_t'(d_stage)), .ymd_o(ymd)
  );

  assign time_o = hms_to_word(hms);
  assign date_o = ymd_to_word(ymd);

  always_comb begin
    ctrl_o = '0;
    ctrl_o[TIME_BUSY_BIT] = t_busy;
    ctrl_o[DATE_BUSY_BIT] = d_busy;
  end
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sec_tick_i,
  input logic        slow_en_i,
  input logic        time_wr_i,
  input logic        date_wr_i,
  input logic [31:0] time_o,
  input logic [31:0] date_o,
  input logic [31:0] ctrl_o
);
  p_time_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i && !(ctrl_o[8] && slow_en_i)) |=> $stable(time_o));

  p_sec_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_o[5:0] <= 6'd59);

  p_day_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    date_o[4:0] != 5'd0);

  p_leap_recalc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !(ctrl_o[8] && slow_en_i) && !(ctrl_o[7] && slow_en_i) &&
     time_o == 32'h00173B3B && date_o[11:8] == 4'd12 && date_o[4:0] == 5'd31)
    |=> (date_o[22] == (date_o[17:16] == 2'd2)));

  p_busy_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_wr_i && !ctrl_o[8]) |=> ctrl_o[8]);

  p_busy_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[8]) |-> $past(slow_en_i));

  p_date_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i && !(ctrl_o[7] && slow_en_i)) |=> $stable(date_o));

  p_busy_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_wr_i && !ctrl_o[7]) |=> ctrl_o[7]);
endmodule

bind cal_counter cal_counter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_tick_i(sec_tick_i), .slow_en_i(slow_en_i),
  .time_wr_i(time_wr_i), .date_wr_i(date_wr_i), .time_o(time_o), .date_o(date_o),
  .ctrl_o(ctrl_o)
);

// File: tb/cal_counter_tb_top.sv
module cal_counter_tb_top;
  localparam int N = 2;
  localparam logic [31:0] MASK_T = 32'h001F3F3F;
  localparam logic [31:0] MASK_D = 32'h007F0F1F;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sec_tick_i = 1'b0, slow_en_i = 1'b0, time_wr_i = 1'b0, date_wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] time_o, date_o, ctrl_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R2";

  logic [31:0] m_time, m_date, m_st, m_sd;
  bit m_bt, m_bd;
  int m_ct, m_cd;

  cal_counter #(.COMMIT_SLOW(N)) dut_i (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] mk_t(int h, int m, int s);
    return {11'd0, h[4:0], 2'd0, m[5:0], 2'd0, s[5:0]};
  endfunction

  function automatic logic [31:0] mk_d(int y, int mo, int d, bit lp);
    return {9'd0, lp, y[5:0], 4'd0, mo[3:0], 3'd0, d[4:0]};
  endfunction

  function automatic int dim(int mo, bit lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] inc_t(logic [31:0] t);
    int s = t[5:0], m = t[13:8], h = t[20:16];
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) h = 0;
    return mk_t(h, m, s);
  endfunction

  function automatic logic [31:0] inc_d(logic [31:0] d);
    int dy = d[4:0], mo = d[11:8], y = d[21:16];
    bit lp = d[22];
    dy++;
    if (dy > dim(mo, lp)) begin
      dy = 1; mo++;
      if (mo == 13) begin
        mo = 1; y = (y + 1) % 64;
        lp = ((y + 1970) % 4) == 0;
      end
    end
    return mk_d(y, mo, dy, lp);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic model_edge(bit tk, bit se, bit wt, bit wd, logic [31:0] d);
    bit ct = m_bt && se && (m_ct == N - 1);
    bit cd = m_bd && se && (m_cd == N - 1);
    bit wrap = tk && !ct && (m_time == mk_t(23, 59, 59));
    if (ct) m_time = m_st; else if (tk) m_time = inc_t(m_time);
    if (cd) m_date = m_sd; else if (wrap) m_date = inc_d(m_date);
    if (!m_bt) begin
      if (wt) begin m_bt = 1; m_ct = 0; m_st = d & MASK_T; end
    end else if (se) begin
      if (m_ct == N - 1) m_bt = 0; else m_ct++;
    end
    if (!m_bd) begin
      if (wd) begin m_bd = 1; m_cd = 0; m_sd = d & MASK_D; end
    end else if (se) begin
      if (m_cd == N - 1) m_bd = 0; else m_cd++;
    end
  endtask

  task automatic step(bit tk, bit se, bit wt, bit wd, logic [31:0] d);
    sec_tick_i = tk; slow_en_i = se; time_wr_i = wt; date_wr_i = wd; wdata_i = d;
    @(posedge clk_i);
    model_edge(tk, se, wt, wd, d);
    @(negedge clk_i);
    sec_tick_i = 0; slow_en_i = 0; time_wr_i = 0; date_wr_i = 0;
    chk({cur_req, " time"}, time_o, m_time);
    chk({cur_req, " date"}, date_o, m_date);
    chk({cur_req, " ctrl"}, ctrl_o, {23'd0, m_bt, m_bd, 7'd0});
  endtask

  task automatic set_time(logic [31:0] v);
    step(0, 0, 1, 0, v);
    step(0, 1, 0, 0, '0);
    step(0, 1, 0, 0, '0);
  endtask

  task automatic set_date(logic [31:0] v);
    step(0, 0, 0, 1, v);
    step(0, 1, 0, 0, '0);
    step(0, 1, 0, 0, '0);
  endtask

  task automatic roll_day(logic [31:0] d, logic [31:0] exp, string req);
    cur_req = req;
    set_date(d);
    set_time(mk_t(23, 59, 59));
    step(1, 0, 0, 0, '0);
    chk(req, time_o, 32'h0);
    chk(req, date_o, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_time = '0; m_date = 32'h101; m_bt = 0; m_bd = 0; m_ct = 0; m_cd = 0;
    m_st = '0; m_sd = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", time_o, 32'h0);
    chk("R1", date_o, 32'h00000101);
    chk("R1", ctrl_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 commit timing
    cur_req = "R7";
    step(1, 0, 1, 0, mk_t(10, 20, 30));
    chk("R7", ctrl_o, 32'h100);
    chk("R7", time_o, mk_t(0, 0, 1));
    step(0, 1, 0, 0, '0);
    chk("R7", ctrl_o, 32'h100);
    step(0, 1, 0, 0, '0);
    chk("R7", ctrl_o, 32'h0);
    chk("R7", time_o, mk_t(10, 20, 30));
    // R2 tick
    cur_req = "R2";
    step(1, 0, 0, 0, '0);
    chk("R2", time_o, mk_t(10, 20, 31));
    // R3 carries
    cur_req = "R3";
    set_time(mk_t(10, 59, 59));
    step(1, 0, 0, 0, '0);
    chk("R3", time_o, mk_t(11, 0, 0));
    // R8 date path, R4 month ends
    cur_req = "R8";
    step(0, 0, 0, 1, mk_d(0, 4, 30, 0));
    chk("R8", ctrl_o, 32'h080);
    step(0, 1, 0, 0, '0);
    step(0, 1, 0, 0, '0);
    chk("R8", date_o, mk_d(0, 4, 30, 0));
    roll_day(mk_d(0, 4, 30, 0), mk_d(0, 5, 1, 0), "R4");
    roll_day(mk_d(0, 1, 31, 0), mk_d(0, 2, 1, 0), "R4");
    roll_day(mk_d(0, 1, 30, 0), mk_d(0, 1, 31, 0), "R4");
    // R5 February
    roll_day(mk_d(1, 2, 28, 0), mk_d(1, 3, 1, 0), "R5");
    roll_day(mk_d(2, 2, 28, 1), mk_d(2, 2, 29, 1), "R5");
    roll_day(mk_d(2, 2, 29, 1), mk_d(2, 3, 1, 1), "R5");
    // R6 year rollover
    roll_day(mk_d(1, 12, 31, 0), mk_d(2, 1, 1, 1), "R6");
    roll_day(mk_d(2, 12, 31, 1), mk_d(3, 1, 1, 0), "R6");
    // R11 range wrap
    roll_day(mk_d(63, 12, 31, 0), mk_d(0, 1, 1, 0), "R11");
    // R9 write while busy
    cur_req = "R9";
    step(0, 0, 1, 0, mk_t(1, 2, 3));
    step(0, 0, 1, 0, mk_t(4, 5, 6));
    step(0, 1, 1, 0, mk_t(7, 8, 9));
    step(0, 1, 0, 0, '0);
    chk("R9", time_o, mk_t(1, 2, 3));
    // R10 commit vs tick at 23:59:59
    cur_req = "R10";
    set_date(mk_d(5, 6, 10, 0));
    set_time(mk_t(23, 59, 59));
    step(0, 0, 1, 0, mk_t(5, 0, 0));
    step(0, 1, 0, 0, '0);
    step(1, 1, 0, 0, '0);
    chk("R10", time_o, mk_t(5, 0, 0));
    chk("R10", date_o, mk_d(5, 6, 10, 0));

    // random phase
    cur_req = "R2/R7/R8 random";
    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom % 4) == 0;
      bit se = ($urandom % 3) == 0;
      bit wt = ($urandom % 20) == 0;
      bit wd = !wt && (($urandom % 20) == 0);
      logic [31:0] d = '0;
      if (wt) d = mk_t($urandom % 24, $urandom % 60, $urandom % 60) | ($urandom & ~MASK_T);
      if (wd) begin
        int y = $urandom % 64, mo = 1 + $urandom % 12;
        bit lp = ((y + 1970) % 4) == 0;
        d = mk_d(y, mo, 1 + $urandom % dim(mo, lp), lp);
      end
      if (($urandom % 50) == 0 && !m_bt) begin
        wt = 1; wd = 0; d = mk_t(23, 59, 58 + $urandom % 2);
      end
      step(tk, se, wt, wd, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule